// File: doc/BRIEF.md
# Hash Message Padding Tail Generator

This block produces the closing words of an MD5 or SHA-1 message as a stream of 32-bit words. A host first streams a message's whole words to a hash core. It then gives this block three things: the count of bytes already sent, the zero to three leftover bytes with their count, and the algorithm. One start pulse makes the block emit everything that ends the message. The first word carries the leftover bytes with the 0x80 marker byte placed right after them. Zero words follow, and then the 64-bit message length in bits. The stream stops exactly on a 64-byte block boundary.

Words use little-endian byte placement: byte 0 of the message stream is bits [7:0] of a word. The output follows a valid/ready handshake. A one-cycle done pulse marks the end of a sequence. A start pulse that arrives while a sequence is in progress has no effect. The hash compression core itself lies outside this block.

Top module: `pad_final_gen`

## Requirements
- R1: After reset, out_valid and done are low and stay low until a start pulse.
- R2: The first word emitted keeps the low tail_cnt×8 bits of tail_data, puts byte 0x80 at byte index tail_cnt (bits [8·tail_cnt+7 : 8·tail_cnt]) and clears every byte above it. With tail_cnt = 0 the first word is 0x00000080.
- R3: Between the first word and the length the block emits Z all-zero words. Let T = byte_count + tail_cnt, F = 64 − (T mod 64), and M = 8 when tail_cnt > 0 or 12 when it is 0. If F < M, add 64 to F. Then Z = (F − M)/4, rounded down.
- R4: For a byte_count that is a multiple of 4, byte_count + 4 × (number of words emitted) is a multiple of 64.
- R5: The two final words carry the 64-bit value L = T × 8.
- R6: With algo_sha = 0 (MD5) the first length word is L[31:0] and the second is L[63:32].
- R7: With algo_sha = 1 (SHA-1) the first length word holds bytes L[63:56], L[55:48], L[47:40], L[39:32] in byte positions 0 to 3. The second holds L[31:24], L[23:16], L[15:8], L[7:0] in byte positions 0 to 3.
- R8: While out_valid is high and out_ready is low, out_valid stays high and out_data is held.
- R9: done is high for exactly one cycle, the cycle after the last length word is accepted, and out_valid is low in that cycle.
- R10: A start pulse while a sequence is in progress changes neither the current sequence nor its word count.
- R11: A start accepted while idle makes out_valid high in the next cycle, with the first word on out_data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a padding sequence (taken only while idle) |
| algo_sha | input | 1 | 1 selects SHA-1 length format, 0 selects MD5 |
| byte_count | input | CNT_W | Message bytes already sent, leftover bytes excluded |
| tail_data | input | 32 | Leftover bytes, byte 0 in bits [7:0] |
| tail_cnt | input | 2 | Number of valid leftover bytes (0 to 3) |
| out_data | output | 32 | Padding word |
| out_valid | output | 1 | out_data holds a word |
| out_ready | input | 1 | Consumer takes the word this cycle |
| done | output | 1 | One-cycle pulse after the final length word is taken |

## Verification
The checker watches the handshake on every cycle: words are held under backpressure, done is a lone pulse that follows an accepted word with valid low, and a start taken while idle raises valid at once. It also checks the 0x80 marker word for a start with no leftover bytes, and it counts words to confirm that every sequence ends on a 64-byte boundary. Only the bench scenarios can show the leftover-byte masking for each count, the exact zero-word count when padding spills into an extra block, the length values in both byte orders, and that a start pulse in mid-sequence is ignored.

// File: rtl/pad_gen_pkg.sv
package pad_gen_pkg;
    localparam int WORD_W   = 32;
    localparam int BYTES_W  = WORD_W / 8;
    localparam int BLOCK_B  = 64;
    localparam int LEN_W    = 64;
    localparam int ZCNT_W   = 5;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TAIL,
        ST_ZERO,
        ST_LEN0,
        ST_LEN1
    } pad_state_e;

    typedef struct packed {
        logic [WORD_W-1:0] first_word;
        logic [ZCNT_W-1:0] zero_words;
        logic [WORD_W-1:0] len_a;
        logic [WORD_W-1:0] len_b;
    } pad_plan_t;
endpackage

// File: rtl/pad_tail_word.sv
module pad_tail_word
    import pad_gen_pkg::*;
(
    input  logic [WORD_W-1:0] tail_data,
    input  logic [1:0]        tail_cnt,
    output logic [WORD_W-1:0] word
);
    for (genvar g = 0; g < BYTES_W; g++) begin : g_byte
        logic keep;
        logic mark;
        assign keep = (g < int'(tail_cnt));
        assign mark = (g == int'(tail_cnt));
        assign word[8*g +: 8] = keep ? tail_data[8*g +: 8] :
                                mark ? 8'h80 : 8'h00;
    end
endmodule

// File: rtl/pad_zero_count.sv
module pad_zero_count
    import pad_gen_pkg::*;
(
    input  logic [5:0]        total_mod,
    input  logic              has_tail,
    output logic [ZCNT_W-1:0] zero_words
);
    logic [7:0] free_b;
    logic [7:0] room_b;
    logic [7:0] span_b;
    logic [7:0] gap_b;

    always_comb begin
        free_b = 8'(BLOCK_B) - {2'b00, total_mod};
        room_b = has_tail ? 8'd8 : 8'd12;
        span_b = (free_b < room_b) ? free_b + 8'(BLOCK_B) : free_b;
        gap_b  = span_b - room_b;
        zero_words = gap_b[ZCNT_W+1:2];
    end
endmodule

// File: rtl/pad_len_fmt.sv
module pad_len_fmt
    import pad_gen_pkg::*;
#(
    parameter int TOT_W = 33
) (
    input  logic [TOT_W-1:0]  total,
    input  logic              algo_sha,
    output logic [WORD_W-1:0] len_a,
    output logic [WORD_W-1:0] len_b
);
    logic [LEN_W-1:0]  bits;
    logic [WORD_W-1:0] swap_hi;
    logic [WORD_W-1:0] swap_lo;

    assign bits = LEN_W'(total) << 3;

    for (genvar g = 0; g < BYTES_W; g++) begin : g_swap
        assign swap_hi[8*g +: 8] = bits[LEN_W-1-8*g -: 8];
        assign swap_lo[8*g +: 8] = bits[WORD_W-1-8*g -: 8];
    end

    assign len_a = algo_sha ? swap_hi : bits[WORD_W-1:0];
    assign len_b = algo_sha ? swap_lo : bits[LEN_W-1:WORD_W];
endmodule

// File: rtl/pad_final_gen.sv
module pad_final_gen
    import pad_gen_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              algo_sha,
    input  logic [CNT_W-1:0]  byte_count,
    input  logic [31:0]       tail_data,
    input  logic [1:0]        tail_cnt,
    output logic [31:0]       out_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic              done
);
    localparam int TOT_W = CNT_W + 1;

    typedef struct packed {
        pad_state_e        state;
        pad_plan_t         plan;
        logic [ZCNT_W-1:0] zleft;
        logic              done;
    } regs_t;

    regs_t             r_q;
    regs_t             r_d;
    logic [TOT_W-1:0]  total;
    pad_plan_t         plan_new;

    assign total = TOT_W'(byte_count) + TOT_W'(tail_cnt);

    pad_tail_word u_tail (
        .tail_data (tail_data),
        .tail_cnt  (tail_cnt),
        .word      (plan_new.first_word)
    );

    pad_zero_count u_zero (
        .total_mod  (total[5:0]),
        .has_tail   (tail_cnt != 2'd0),
        .zero_words (plan_new.zero_words)
    );

    pad_len_fmt #(.TOT_W(TOT_W)) u_len (
        .total    (total),
        .algo_sha (algo_sha),
        .len_a    (plan_new.len_a),
        .len_b    (plan_new.len_b)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (start) begin
                    r_d.plan  = plan_new;
                    r_d.state = ST_TAIL;
                end
            end
            ST_TAIL: begin
                if (out_ready) begin
                    r_d.zleft = r_q.plan.zero_words;
                    r_d.state = (r_q.plan.zero_words != '0) ? ST_ZERO : ST_LEN0;
                end
            end
            ST_ZERO: begin
                if (out_ready) begin
                    r_d.zleft = r_q.zleft - 1'b1;
                    if (r_q.zleft == ZCNT_W'(1)) r_d.state = ST_LEN0;
                end
            end
            ST_LEN0: begin
                if (out_ready) r_d.state = ST_LEN1;
            end
            ST_LEN1: begin
                if (out_ready) begin
                    r_d.state = ST_IDLE;
                    r_d.done  = 1'b1;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, plan: '0, zleft: '0, done: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        unique case (r_q.state)
            ST_TAIL: out_data = r_q.plan.first_word;
            ST_LEN0: out_data = r_q.plan.len_a;
            ST_LEN1: out_data = r_q.plan.len_b;
            default: out_data = '0;
        endcase
    end

    assign out_valid = (r_q.state != ST_IDLE);
    assign done      = r_q.done;
endmodule

// File: rtl/pad_final_gen_chk.sv
module pad_final_gen_chk #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [CNT_W-1:0] byte_count,
    input logic [1:0]       tail_cnt,
    input logic [31:0]      out_data,
    input logic             out_valid,
    input logic             out_ready,
    input logic             done
);
    logic [5:0] cap_q;
    logic [5:0] words_q;
    logic [7:0] end_pos;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_q   <= '0;
            words_q <= '0;
        end else if (start && !out_valid) begin
            cap_q   <= byte_count[5:0];
            words_q <= '0;
        end else if (out_valid && out_ready) begin
            words_q <= words_q + 1'b1;
        end
    end

    assign end_pos = {2'b00, cap_q} + {words_q, 2'b00};

    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data));

    assert_done_after_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !out_valid && $past(out_valid && out_ready));

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_first_valid_R11: assert property (@(posedge clk) disable iff (!rst_n)
        start && !out_valid |=> out_valid);

    assert_marker_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start && !out_valid && tail_cnt == 2'd0 |=> out_data == 32'h0000_0080);

    assert_block_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done && cap_q[1:0] == 2'b00 |-> end_pos[5:0] == 6'd0);
endmodule

bind pad_final_gen pad_final_gen_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .byte_count (byte_count),
    .tail_cnt   (tail_cnt),
    .out_data   (out_data),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .done       (done)
);

// File: tb/sim_pad_final_gen.sv
module sim_pad_final_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        algo_sha = 1'b0;
    logic [31:0] byte_count = '0;
    logic [31:0] tail_data = '0;
    logic [1:0]  tail_cnt = '0;
    logic [31:0] out_data;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic        done;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    logic [31:0] got [0:39];
    int n_got;
    logic done_seen;

    always #10 clk = ~clk;

    pad_final_gen #(.CNT_W(32)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .algo_sha(algo_sha),
        .byte_count(byte_count), .tail_data(tail_data), .tail_cnt(tail_cnt),
        .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready),
        .done(done)
    );

    typedef struct packed {
        logic        sha;
        logic [31:0] bc;
        logic [31:0] tail;
        logic [1:0]  cnt;
        logic [31:0] exp_first;
        logic [5:0]  exp_words;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VEC [0:NV-1] = '{
        '{1'b0, 32'd0,          32'hDEAD_BEEF, 2'd0, 32'h0000_0080, 6'd16},
        '{1'b1, 32'd56,         32'h0,         2'd0, 32'h0000_0080, 6'd18},
        '{1'b0, 32'd60,         32'hAABB_CCDD, 2'd3, 32'h80BB_CCDD, 6'd17},
        '{1'b1, 32'd4,          32'h1234_5678, 2'd1, 32'h0000_8078, 6'd15},
        '{1'b0, 32'd52,         32'hFFFF_FFFF, 2'd2, 32'h0080_FFFF, 6'd3},
        '{1'b1, 32'h1234_5670,  32'h0,         2'd0, 32'h0000_0080, 6'd4},
        '{1'b0, 32'd48,         32'h5555_5555, 2'd0, 32'h0000_0080, 6'd4},
        '{1'b1, 32'd52,         32'h1122_3344, 2'd3, 32'h8022_3344, 6'd3},
        '{1'b1, 32'd56,         32'h99AA_BBCC, 2'd1, 32'h0000_80CC, 6'd18}
    };

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            fails = fails + 1;
            $display("FAIL R9 watchdog expired: actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    task automatic check(input logic ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks = checks + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] bswap(input logic [31:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction

    // bp: 1 applies backpressure; inject: loop step at which a stray start is driven (-1: none)
    task automatic run_frame(input vec_t v, input bit bp, input int inject);
        logic        held_v;
        logic [31:0] held_d;
        int          step;
        held_v = 1'b0;
        held_d = '0;
        step = 0;
        @(negedge clk);
        algo_sha = v.sha; byte_count = v.bc; tail_data = v.tail; tail_cnt = v.cnt;
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        check(out_valid == 1'b1, "R11 valid after start", 32'(out_valid), 32'd1);
        n_got = 0;
        done_seen = 1'b0;
        while (step < 200) begin
            if (done) begin
                done_seen = 1'b1;
                break;
            end
            out_ready = bp ? ((step % 3) != 1) : 1'b1;
            if (held_v) begin
                check(out_valid && out_data == held_d, "R8 held word", out_data, held_d);
                held_v = 1'b0;
            end
            if (out_valid && out_ready) begin
                if (n_got < 40) got[n_got] = out_data;
                n_got = n_got + 1;
            end else if (out_valid) begin
                held_v = 1'b1;
                held_d = out_data;
            end
            if (step == inject) begin
                start = 1'b1; algo_sha = ~v.sha; byte_count = 32'd8; tail_cnt = 2'd2;
            end else begin
                start = 1'b0;
            end
            step = step + 1;
            @(posedge clk);
            @(negedge clk);
        end
        start = 1'b0;
        out_ready = 1'b0;
        check(done_seen, "R9 done seen", 32'(done_seen), 32'd1);
        check(!out_valid, "R9 valid low with done", 32'(out_valid), 32'd0);
        @(negedge clk);
        check(!done, "R9 done one cycle", 32'(done), 32'd0);
    endtask

    task automatic check_stream(input vec_t v, input string tag);
        logic [63:0] bits;
        logic [31:0] ea;
        logic [31:0] eb;
        int          nz;
        bits = 64'(33'(v.bc) + 33'(v.cnt)) << 3;
        if (v.sha) begin
            ea = bswap(bits[63:32]);
            eb = bswap(bits[31:0]);
        end else begin
            ea = bits[31:0];
            eb = bits[63:32];
        end
        check(n_got == int'(v.exp_words), {tag, " R3 R4 word count"}, 32'(n_got),
              32'(v.exp_words));
        if (n_got == int'(v.exp_words) && n_got >= 3) begin
            check(got[0] == v.exp_first, {tag, " R2 first word"}, got[0], v.exp_first);
            nz = 0;
            for (int i = 1; i < n_got - 2; i++) if (got[i] != 32'd0) nz = nz + 1;
            check(nz == 0, {tag, " R3 zero words"}, 32'(nz), 32'd0);
            check(got[n_got-2] == ea, {tag, v.sha ? " R5 R7 len word a" : " R5 R6 len word a"},
                  got[n_got-2], ea);
            check(got[n_got-1] == eb, {tag, v.sha ? " R5 R7 len word b" : " R5 R6 len word b"},
                  got[n_got-1], eb);
        end
    endtask

    initial begin
        // R1: reset state
        repeat (2) @(negedge clk);
        check(!out_valid && !done, "R1 during reset", {30'd0, out_valid, done}, 32'd0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(!out_valid && !done, "R1 idle after reset", {30'd0, out_valid, done}, 32'd0);

        // table walk
        for (int k = 0; k < NV; k++) begin
            run_frame(VEC[k], 1'b0, -1);
            check_stream(VEC[k], $sformatf("vec%0d", k));
        end

        // R8: backpressure on a spill frame
        run_frame(VEC[2], 1'b1, -1);
        check_stream(VEC[2], "backpressure");

        // R10: stray start in mid-sequence
        run_frame(VEC[1], 1'b0, 3);
        check_stream(VEC[1], "R10 busy start");
        repeat (3) @(negedge clk);
        check(!out_valid, "R10 no second sequence", 32'(out_valid), 32'd0);

        // R10 with backpressure and start on a stalled cycle
        run_frame(VEC[8], 1'b1, 1);
        check_stream(VEC[8], "R10 stalled start");

        // R1: no output without start
        repeat (4) @(negedge clk);
        check(!out_valid && !done, "R1 quiet idle", {30'd0, out_valid, done}, 32'd0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule